// File: doc/BRIEF.md
# Keyed Flash Programming Launch Register

This block is the byte-wide control register through which a processor starts a flash programming operation. Software writes it over a simple byte bus with a write strobe. The register holds three fields: a launch-key nibble, a bit that maps the page latches into data space, and a two-bit target selector. Bit 0 reads back the busy flag, which comes from the programming engine. Software cannot write that bit.

A launch is guarded by a two-write key. The first write puts 5h in the upper nibble. The second write puts Ah there and must come in the very next instruction with the same target selector. The processor marks the end of each instruction with a one-cycle boundary pulse, and the block counts these pulses to decide whether the two writes were adjacent. A correct pair gives a one-cycle launch pulse that carries the target selector to the engine. The pair must also be issued while the processor runs from the boot array. Any other pattern drops the sequence without side effects: a gap, a different selector, the reserved selector, an unexpected nibble, or running from outside the boot array.

Top module: `flash_launch_ctrl`

## Requirements
- R1: After reset `rd_data` reads 00h and `launch` is low.
- R2: A write stores bits 7:4 (key), bit 3 (latch map) and bits 2:1 (target) of `wr_data`. These are visible on `rd_data` from the next cycle. `rd_data[0]` always equals `eng_busy`, and bit 0 of a write is discarded.
- R3: A write with key 5h and no following Ah write produces no launch.
- R4: Target 00 selects the user array, 01 the extra row and 10 the security byte. A write with key 5h and target t in {00,01,10} is called the arming write. A launch happens when it is followed by a write with key Ah and the same target t, with exactly one boundary pulse seen after the arming write's cycle and before the Ah write's cycle. `launch` is then high for exactly the one cycle after the Ah write, with `launch_mode` = t.
- R5: If two or more boundary pulses fall between the arming write and the Ah write, there is no launch.
- R6: If the Ah write carries a target different from the arming write, there is no launch.
- R7: Target 11 is reserved. A 5h write with target 11 arms nothing, and no launch ever carries mode 11.
- R8: An Ah write while `boot_exec` is low does not launch, and it returns the sequence to idle.
- R9: While `eng_busy` is high, writes change no field and do not advance or abort the key sequence.
- R10: A write whose key is neither the expected 5h nor the expected Ah returns the sequence to idle. A later Ah write then does not launch.
- R11: A write in the same cycle as a boundary pulse belongs to the instruction that is ending. A 5h write together with a pulse, followed by an Ah write, launches. An Ah write together with the first pulse after arming also launches. A 5h write without a pulse followed at once by an Ah write does not launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| insn_end | input | 1 | One-cycle pulse at the end of each instruction |
| boot_exec | input | 1 | High while code runs from the boot array |
| eng_busy | input | 1 | Busy flag from the programming engine |
| rd_data | output | 8 | Register read value |
| launch | output | 1 | One-cycle programming start pulse |
| launch_mode | output | 2 | Target selector carried with the start pulse |

## Verification
Two things can happen in the same cycle: a register write and an instruction boundary pulse. When they coincide, the block must assign the write to the instruction that is ending before it counts the pulse. The bench provokes this by putting the Ah write on the cycle of the first boundary after arming, and by placing the 5h write on, or off, a boundary pulse. A behavioural model compares the launch pulse and its mode against the block on every cycle, and the bench also checks the launch count after each scenario.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;
   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_state_e;
endpackage

// File: rtl/flc_fields.sv
`timescale 1ns/1ps
module flc_fields #(
   parameter int DATA_W = 8,
   parameter int KEY_W  = 4,
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_busy,
   output logic [KEY_W-1:0]  key_q,
   output logic              map_q,
   output logic [MODE_W-1:0] mode_q
);
   localparam int MODE_LSB = 1;
   localparam int MAP_BIT  = MODE_LSB + MODE_W;
   localparam int KEY_LSB  = MAP_BIT + 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q  <= '0;
         map_q  <= 1'b0;
         mode_q <= '0;
      end else if (wr_ok) begin
         key_q  <= wr_data[KEY_LSB +: KEY_W];
         map_q  <= wr_data[MAP_BIT];
         mode_q <= wr_data[MODE_LSB +: MODE_W];
      end
   end

   AST_FIELDS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> ($stable(key_q) && $stable(map_q) && $stable(mode_q))); // R9
endmodule

// File: rtl/flc_key_seq.sv
`timescale 1ns/1ps
module flc_key_seq
   import flc_pkg::*;
#(
   parameter int              KEY_W     = 4,
   parameter int              MODE_W    = 2,
   parameter logic [KEY_W-1:0]  KEY_ARM  = 4'h5,
   parameter logic [KEY_W-1:0]  KEY_FIRE = 4'hA,
   parameter logic [MODE_W-1:0] RES_MODE = 2'b11,
   parameter bit              BOOT_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic              insn_end,
   input  logic              boot_exec,
   output logic              launch,
   output logic [MODE_W-1:0] launch_mode
);
   localparam int GAP_W = 2;

   seq_state_e        state_q;
   logic [GAP_W-1:0]  gaps_q;
   logic [MODE_W-1:0] arm_mode_q;
   logic              boot_ok;
   logic              is_arm, is_fire;

   generate
      if (BOOT_GATE) begin : g_boot_gate
         assign boot_ok = boot_exec;
      end else begin : g_no_boot_gate
         assign boot_ok = 1'b1;
      end
   endgenerate

   assign is_arm  = (wr_key == KEY_ARM) && (wr_mode != RES_MODE);
   assign is_fire = (wr_key == KEY_FIRE) && (state_q == SEQ_ARMED) &&
                    (gaps_q == GAP_W'(1)) && (wr_mode == arm_mode_q) && boot_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SEQ_IDLE;
         gaps_q      <= '0;
         arm_mode_q  <= '0;
         launch      <= 1'b0;
         launch_mode <= '0;
      end else begin
         launch <= 1'b0;
         if (state_q == SEQ_ARMED && insn_end) begin
            if (gaps_q == GAP_W'(1)) state_q <= SEQ_IDLE;
            else                     gaps_q  <= gaps_q + GAP_W'(1);
         end
         if (wr_ok) begin
            if (is_arm) begin
               state_q    <= SEQ_ARMED;
               arm_mode_q <= wr_mode;
               gaps_q     <= insn_end ? GAP_W'(1) : GAP_W'(0);
            end else if (is_fire) begin
               state_q     <= SEQ_IDLE;
               launch      <= 1'b1;
               launch_mode <= wr_mode;
            end else begin
               state_q <= SEQ_IDLE;
            end
         end
      end
   end

   AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch); // R4
   AST_LAUNCH_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(launch) |-> $past(wr_ok && wr_key == KEY_FIRE && state_q == SEQ_ARMED)); // R4
   AST_NO_RESERVED_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (launch_mode != RES_MODE)); // R7
   AST_LAUNCH_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(launch) |-> (launch_mode == $past(arm_mode_q))); // R6
   generate
      if (BOOT_GATE) begin : g_boot_chk
         AST_BOOT_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(launch) |-> $past(boot_exec)); // R8
      end
   endgenerate
endmodule

// File: rtl/flash_launch_ctrl.sv
`timescale 1ns/1ps
module flash_launch_ctrl #(
   parameter int              DATA_W    = 8,
   parameter int              KEY_W     = 4,
   parameter int              MODE_W    = 2,
   parameter logic [KEY_W-1:0]  KEY_ARM  = 4'h5,
   parameter logic [KEY_W-1:0]  KEY_FIRE = 4'hA,
   parameter logic [MODE_W-1:0] RES_MODE = 2'b11,
   parameter bit              BOOT_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              insn_end,
   input  logic              boot_exec,
   input  logic              eng_busy,
   output logic [DATA_W-1:0] rd_data,
   output logic              launch,
   output logic [MODE_W-1:0] launch_mode
);
   localparam int MODE_LSB = 1;
   localparam int KEY_LSB  = MODE_LSB + MODE_W + 1;

   generate
      if (DATA_W != KEY_W + MODE_W + 2) begin : g_bad_layout
         $error("flash_launch_ctrl: DATA_W must equal KEY_W + MODE_W + 2");
      end
      if (KEY_ARM == KEY_FIRE) begin : g_bad_keys
         $error("flash_launch_ctrl: arming and firing keys must differ");
      end
   endgenerate

   logic              wr_ok;
   logic [KEY_W-1:0]  key_q;
   logic              map_q;
   logic [MODE_W-1:0] mode_q;

   assign wr_ok = wr_en && !eng_busy;

   flc_fields #(.DATA_W(DATA_W), .KEY_W(KEY_W), .MODE_W(MODE_W)) u_fields (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_data(wr_data),
      .eng_busy(eng_busy), .key_q(key_q), .map_q(map_q), .mode_q(mode_q));

   flc_key_seq #(.KEY_W(KEY_W), .MODE_W(MODE_W), .KEY_ARM(KEY_ARM),
      .KEY_FIRE(KEY_FIRE), .RES_MODE(RES_MODE), .BOOT_GATE(BOOT_GATE)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
      .wr_key(wr_data[KEY_LSB +: KEY_W]), .wr_mode(wr_data[MODE_LSB +: MODE_W]),
      .insn_end(insn_end), .boot_exec(boot_exec),
      .launch(launch), .launch_mode(launch_mode));

   assign rd_data = {key_q, map_q, mode_q, eng_busy};

   AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] == eng_busy); // R2
   AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eng_busy) |-> !launch); // R9
endmodule

// File: tb/flash_launch_ctrl_tb.sv
`timescale 1ns/1ps
module flash_launch_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       insn_end = 1'b0;
   logic       boot_exec = 1'b1;
   logic       eng_busy = 1'b0;
   logic [7:0] rd_data;
   logic       launch;
   logic [1:0] launch_mode;

   int checks = 0;
   int failures = 0;
   int launches = 0;
   int last_mode = -1;

   // behavioural model state
   int m_key = 0, m_map = 0, m_mode = 0;
   int m_armed = 0, m_gaps = 0, m_amode = 0;
   int m_launch = 0, m_lmode = 0;

   always #4 clk = ~clk;

   flash_launch_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .insn_end(insn_end), .boot_exec(boot_exec), .eng_busy(eng_busy),
      .rd_data(rd_data), .launch(launch), .launch_mode(launch_mode));

   always @(posedge clk) begin
      int k, md;
      int nxt_armed, nxt_gaps;
      if (!rst_n) begin
         m_key = 0; m_map = 0; m_mode = 0;
         m_armed = 0; m_gaps = 0; m_amode = 0; m_launch = 0; m_lmode = 0;
      end else begin
         k  = int'(wr_data[7:4]);
         md = int'(wr_data[2:1]);
         nxt_armed = m_armed;
         nxt_gaps  = m_gaps;
         m_launch  = 0;
         if (m_armed != 0 && insn_end) begin
            if (m_gaps >= 1) nxt_armed = 0;
            else nxt_gaps = m_gaps + 1;
         end
         if (wr_en && !eng_busy) begin
            if (k == 5 && md != 3) begin
               nxt_armed = 1; m_amode = md; nxt_gaps = insn_end ? 1 : 0;
            end else if (k == 10 && m_armed != 0 && m_gaps == 1 &&
                         md == m_amode && boot_exec) begin
               nxt_armed = 0; m_launch = 1; m_lmode = md;
            end else begin
               nxt_armed = 0;
            end
            m_key = k; m_map = int'(wr_data[3]); m_mode = md;
         end
         m_armed = nxt_armed;
         m_gaps  = nxt_gaps;
      end
   end

   function automatic logic [7:0] model_rd();
      return {m_key[3:0], m_map[0], m_mode[1:0], eng_busy};
   endfunction

   // per-cycle comparison, sampled 2 ns after the rising edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         checks++;
         if (rd_data !== model_rd()) begin
            failures++;
            $display("FAIL R2 model rd_data actual=%h expected=%h t=%0t", rd_data, model_rd(), $time);
         end
         checks++;
         if (launch !== m_launch[0] || (launch && launch_mode !== m_lmode[1:0])) begin
            failures++;
            $display("FAIL R4 model launch actual=%b/%0d expected=%0d/%0d t=%0t",
                     launch, launch_mode, m_launch, m_lmode, $time);
         end
         if (launch) begin
            launches++;
            last_mode = int'(launch_mode);
         end
      end
   end

   task automatic cyc(input logic we, input logic [7:0] d, input logic ie);
      @(negedge clk);
      wr_en = we; wr_data = d; insn_end = ie;
      @(negedge clk);
      wr_en = 1'b0; insn_end = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      // R1 reset state
      chk("R1 rd_data after reset", int'(rd_data), 0);
      chk("R1 launch after reset", int'(launch), 0);

      // R2 field storage, bit 0 not writable
      cyc(1, 8'h0F, 0); @(posedge clk); #2;
      chk("R2 readback of 0Fh write", int'(rd_data), 8'h0E);
      eng_busy = 1'b1; @(posedge clk); #2;
      chk("R2 busy visible in bit0", int'(rd_data), 8'h0F);
      eng_busy = 1'b0; cyc(1, 8'h00, 0);

      // R4 launch user array, boundary on arming write
      base = launches;
      cyc(1, 8'h50, 1); cyc(1, 8'hA0, 0); settle();
      chk("R4 launch count mode 00", launches - base, 1);
      chk("R4 launch mode 00", last_mode, 0);
      // R4 extra row
      base = launches;
      cyc(1, 8'h52, 1); cyc(1, 8'hA2, 0); settle();
      chk("R4 launch count mode 01", launches - base, 1);
      chk("R4 launch mode 01", last_mode, 1);
      // R4 security byte, boundary on its own cycle
      base = launches;
      cyc(1, 8'h54, 0); cyc(0, 8'h00, 1); cyc(1, 8'hA4, 0); settle();
      chk("R4 launch count mode 10", launches - base, 1);
      chk("R4 launch mode 10", last_mode, 2);

      // R3 arming alone
      base = launches;
      cyc(1, 8'h50, 1); cyc(0, 8'h00, 1); settle();
      chk("R3 lone 5h write", launches - base, 0);

      // R5 extra instruction between
      base = launches;
      cyc(1, 8'h50, 1); cyc(0, 8'h00, 1); cyc(1, 8'hA0, 0); settle();
      chk("R5 gap aborts", launches - base, 0);

      // R6 mode mismatch
      base = launches;
      cyc(1, 8'h52, 1); cyc(1, 8'hA0, 0); settle();
      chk("R6 mode mismatch aborts", launches - base, 0);

      // R7 reserved mode
      base = launches;
      cyc(1, 8'h56, 1); cyc(1, 8'hA6, 0); settle();
      chk("R7 reserved mode no launch", launches - base, 0);

      // R8 not from boot array, then retry without rearm
      base = launches;
      boot_exec = 1'b0;
      cyc(1, 8'h50, 1); cyc(1, 8'hA0, 1);
      boot_exec = 1'b1;
      cyc(1, 8'hA0, 0); settle();
      chk("R8 boot gate and idle after", launches - base, 0);

      // R9 writes ignored while busy
      cyc(1, 8'h00, 0);
      eng_busy = 1'b1;
      cyc(1, 8'h3C, 0); @(posedge clk); #2;
      chk("R9 busy write ignored", int'(rd_data), 8'h01);
      base = launches;
      cyc(1, 8'h50, 1); cyc(1, 8'hA0, 0); settle();
      chk("R9 no launch when busy", launches - base, 0);
      eng_busy = 1'b0;
      // R9 armed sequence survives a busy-ignored write
      base = launches;
      cyc(1, 8'h50, 1);
      eng_busy = 1'b1; cyc(1, 8'h30, 0); eng_busy = 1'b0;
      cyc(1, 8'hA0, 0); settle();
      chk("R9 ignored write keeps arming", launches - base, 1);

      // R10 unexpected nibble
      base = launches;
      cyc(1, 8'h50, 1); cyc(1, 8'h30, 1); cyc(1, 8'hA0, 0); settle();
      chk("R10 wrong nibble resets", launches - base, 0);

      // R11 write coincident with boundary
      base = launches;
      cyc(1, 8'h52, 1); cyc(1, 8'hA2, 1); settle();
      chk("R11 fire on boundary cycle", launches - base, 1);
      base = launches;
      cyc(1, 8'h50, 0); cyc(1, 8'hA0, 0); settle();
      chk("R11 same instruction no launch", launches - base, 0);

      // R1 reset mid-sequence clears arming
      base = launches;
      cyc(1, 8'h50, 1);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      cyc(1, 8'hA0, 0); settle();
      chk("R1 reset clears arming", launches - base, 0);
      chk("R1 rd_data after reset and A0", int'(rd_data), 8'hA0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule